// File: doc/BRIEF.md
# Transmit Mailbox Status Register

This block holds the per-mailbox status of the transmit side of a CAN controller. Each of the three transmit mailboxes has five visible bits: a request-done flag, a sent-OK flag, a lost-arbitration flag, a bus-error flag and an abort-request bit. The transmit engine reports the end of each attempt through one event pulse per outcome, and a send-request pulse marks the start of a new request for a mailbox. Software reads the status through a 32-bit register and changes it through byte-enabled writes.

The flags are linked. When the done flag is cleared, either by software writing 1 to it or by a new send request, the three outcome flags clear in the same cycle. Software can set the abort bit, but only while a send is pending for that mailbox. Hardware clears the abort bit when the mailbox returns to idle. The abort bit drives an output to the transmit engine. The engine finishes the abort and reports it with an abort-done pulse.

Top module: `txmb_status`

## Requirements
- R1: The read word gives mailbox i the byte lane [8i+7:8i]. Within a lane, bit 0 is request-done, bit 1 is sent-OK, bit 2 is lost-arbitration, bit 3 is bus-error and bit 7 is abort-request. Bits 6:4 of each lane and bits 31:24 always read 0.
- R2: After a synchronous reset, every bit of the read word is 0, every abort output is 0 and every mailbox is idle.
- R3: A send-request pulse to an idle mailbox makes it pending, and one cycle later request-done, sent-OK, lost-arbitration and bus-error are all 0. A send-request pulse to a mailbox that is already pending has no effect.
- R4: An outcome event (ok, arbitration lost, error or abort-done) to a pending mailbox returns it to idle and sets request-done. It also sets sent-OK to the value of the ok event, sets lost-arbitration if the arbitration event is present, and sets bus-error if the error event is present. Events to an idle mailbox have no effect.
- R5: A write with wr_en high, the mailbox's byte enable high and 1 in that lane's bit 0 clears request-done together with sent-OK, lost-arbitration and bus-error. Writing 0 there, or writing with that byte enable low, has no effect.
- R6: Writes to sent-OK, lost-arbitration and bus-error (lane bits 1 to 3) have no effect.
- R7: When an outcome event and a request-done write-1-to-clear reach the same mailbox in the same cycle, the event wins. Request-done ends at 1, and the outcome flags take the event's values.
- R8: Writing 1 to lane bit 7 sets that mailbox's abort bit and its abort_pend output, but only while the mailbox is pending and no event or send request acts on it in that cycle. Written while the mailbox is idle, the bit stays 0.
- R9: The abort bit and abort_pend clear in the cycle in which the mailbox returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_req | input | NUM_MB | One-cycle send-request pulse per mailbox |
| ev_ok | input | NUM_MB | Attempt succeeded |
| ev_arb_lost | input | NUM_MB | Attempt failed on lost arbitration |
| ev_err | input | NUM_MB | Attempt failed on a bus error |
| ev_abort_done | input | NUM_MB | Requested abort finished |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | BUS_W/8 | Byte enables of the write |
| wr_data | input | BUS_W | Write data |
| rd_data | output | BUS_W | Status word |
| abort_pend | output | NUM_MB | Abort requested, one bit per mailbox |

## Verification
The hardest case to reach is the collision of a hardware set and a software clear on the same flag in the same cycle. The bench first puts a mailbox into the pending state. It then drives the ok event and a write-1-to-clear of request-done in one cycle and checks that the set wins. The abort bit needs a similar setup: it can only be observed after a send is pending. The bench therefore checks that a repeated send request leaves a set abort bit in place, and that an abort-done pulse then clears that bit.

// File: rtl/txmb_pkg.sv
package txmb_pkg;

    localparam int LANE_W   = 8;
    localparam int DONE_BIT = 0;
    localparam int ABRT_BIT = 7;

    // outcome events from the transmit engine for one mailbox
    typedef struct packed {
        logic ok;
        logic arb;
        logic err;
        logic abt;
    } mb_evt_t;

    // visible status byte of one mailbox, MSB first
    typedef struct packed {
        logic       abort;
        logic [2:0] zero;
        logic       berr;
        logic       arbl;
        logic       sent;
        logic       done;
    } mb_lane_t;

    function automatic logic evt_any(mb_evt_t e);
        return e.ok | e.arb | e.err | e.abt;
    endfunction

    function automatic mb_lane_t make_lane(logic abort, logic berr, logic arbl,
                                           logic sent, logic done);
        mb_lane_t l;
        l.abort = abort;
        l.zero  = '0;
        l.berr  = berr;
        l.arbl  = arbl;
        l.sent  = sent;
        l.done  = done;
        return l;
    endfunction

endpackage

// File: rtl/txmb_slot.sv
module txmb_slot
    import txmb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     send_req,
    input  mb_evt_t  evt,
    input  logic     clr_done,
    input  logic     set_abort,
    output mb_lane_t lane,
    output logic     abort_pend
);

    logic pend_q, done_q, sent_q, arbl_q, berr_q, abort_q;
    logic start, finish;

    assign start  = send_req & ~pend_q;
    assign finish = pend_q & evt_any(evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
            sent_q  <= 1'b0;
            arbl_q  <= 1'b0;
            berr_q  <= 1'b0;
            abort_q <= 1'b0;
        end else if (start) begin
            pend_q  <= 1'b1;
            done_q  <= 1'b0;
            sent_q  <= 1'b0;
            arbl_q  <= 1'b0;
            berr_q  <= 1'b0;
            abort_q <= 1'b0;
        end else if (finish) begin
            pend_q  <= 1'b0;
            done_q  <= 1'b1;
            sent_q  <= evt.ok;
            arbl_q  <= arbl_q | evt.arb;
            berr_q  <= berr_q | evt.err;
            abort_q <= 1'b0;
        end else begin
            if (clr_done) begin
                done_q <= 1'b0;
                sent_q <= 1'b0;
                arbl_q <= 1'b0;
                berr_q <= 1'b0;
            end
            if (set_abort && pend_q)
                abort_q <= 1'b1;
        end
    end

    assign lane       = make_lane(abort_q, berr_q, arbl_q, sent_q, done_q);
    assign abort_pend = abort_q;

    // R8
    abort_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        abort_q |-> pend_q);

    // R5
    flags_follow_done_chk: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> (!sent_q && !arbl_q && !berr_q));

    // R3
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (send_req && !pend_q) |=> (pend_q && !done_q && !abort_q));

    // R4
    finish_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && evt_any(evt)) |=> (done_q && !pend_q));

    // R9
    abort_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q) |-> !abort_q);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && evt.ok && clr_done) |=> (done_q && sent_q));

endmodule

// File: rtl/txmb_status.sv
module txmb_status
    import txmb_pkg::*;
#(
    parameter int NUM_MB = 3,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_MB-1:0] send_req,
    input  logic [NUM_MB-1:0] ev_ok,
    input  logic [NUM_MB-1:0] ev_arb_lost,
    input  logic [NUM_MB-1:0] ev_err,
    input  logic [NUM_MB-1:0] ev_abort_done,
    input  logic              wr_en,
    input  logic [BUS_W/8-1:0] wr_be,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    output logic [NUM_MB-1:0] abort_pend
);

    localparam int LANES = BUS_W / LANE_W;

    logic wr_unused;
    assign wr_unused = ^{wr_data, wr_be};

    initial begin
        if (NUM_MB > LANES)
            $error("txmb_status: more mailboxes than byte lanes");
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < NUM_MB) begin : g_mb
            mb_evt_t  evt;
            mb_lane_t lane;
            logic     lane_wr;

            assign evt.ok  = ev_ok[i];
            assign evt.arb = ev_arb_lost[i];
            assign evt.err = ev_err[i];
            assign evt.abt = ev_abort_done[i];
            assign lane_wr = wr_en & wr_be[i];

            txmb_slot u_slot (
                .clk        (clk),
                .rst        (rst),
                .send_req   (send_req[i]),
                .evt        (evt),
                .clr_done   (lane_wr & wr_data[i*LANE_W + DONE_BIT]),
                .set_abort  (lane_wr & wr_data[i*LANE_W + ABRT_BIT]),
                .lane       (lane),
                .abort_pend (abort_pend[i])
            );

            assign rd_data[i*LANE_W +: LANE_W] = lane;
        end else begin : g_pad
            assign rd_data[i*LANE_W +: LANE_W] = '0;
        end
    end

endmodule

// File: tb/txmb_status_tb_top.sv
`timescale 1ns/1ps
module txmb_status_tb_top;

    localparam int N = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  send_req = '0, ev_ok = '0, ev_arb_lost = '0, ev_err = '0, ev_abort_done = '0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_be = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [N-1:0]  abort_pend;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    txmb_status #(.NUM_MB(N), .BUS_W(32)) dut_i (
        .clk(clk), .rst(rst), .send_req(send_req), .ev_ok(ev_ok),
        .ev_arb_lost(ev_arb_lost), .ev_err(ev_err), .ev_abort_done(ev_abort_done),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_data(rd_data), .abort_pend(abort_pend)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // drive one cycle of stimulus, then release everything
    task automatic apply();
        cyc();
        send_req = '0; ev_ok = '0; ev_arb_lost = '0; ev_err = '0; ev_abort_done = '0;
        wr_en = 1'b0; wr_be = '0; wr_data = '0;
    endtask

    task automatic bus_wr(logic [3:0] be, logic [31:0] d);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        apply();
    endtask

    task automatic t_reset();
        check("R2 status word", rd_data, 32'h0);
        check("R2 abort outputs", {29'h0, abort_pend}, 32'h0);
    endtask

    task automatic t_send_ok();
        send_req[0] = 1'b1; apply();
        check("R3 after send mb0", rd_data, 32'h0);
        bus_wr(4'b0001, 32'h80);
        check("R8 abort set while pending", rd_data, 32'h80);
        check("R8 abort_pend mb0", {29'h0, abort_pend}, 32'h1);
        ev_ok[0] = 1'b1; apply();
        check("R4 ok outcome mb0", rd_data, 32'h03);
        check("R9 abort cleared at idle", {29'h0, abort_pend}, 32'h0);
    endtask

    task automatic t_arb_err();
        send_req[1] = 1'b1; apply();
        ev_arb_lost[1] = 1'b1; apply();
        check("R4 arb lost mb1", rd_data, 32'h0503);
        send_req[1] = 1'b1; apply();
        check("R3 new send clears flags mb1", rd_data, 32'h0003);
        ev_err[1] = 1'b1; apply();
        check("R4 error mb1", rd_data, 32'h0903);
    endtask

    task automatic t_clear();
        bus_wr(4'b0010, 32'h0);
        check("R5 write 0 no effect", rd_data, 32'h0903);
        bus_wr(4'b0000, 32'h0100);
        check("R5 byte enable low no effect", rd_data, 32'h0903);
        bus_wr(4'b0010, 32'h0E00);
        check("R6 read-only flag bits", rd_data, 32'h0903);
        bus_wr(4'b0010, 32'h0100);
        check("R5 w1c clears done and flags", rd_data, 32'h0003);
    endtask

    task automatic t_set_wins();
        send_req[2] = 1'b1; apply();
        ev_ok[2] = 1'b1;
        wr_en = 1'b1; wr_be = 4'b0100; wr_data = 32'h0001_0000;
        apply();
        check("R7 set beats clear mb2", rd_data, 32'h0003_0003);
    endtask

    task automatic t_abort_idle();
        bus_wr(4'b0001, 32'h80);
        check("R8 abort while idle ignored", rd_data, 32'h0003_0003);
        check("R8 abort_pend stays 0", {29'h0, abort_pend}, 32'h0);
        ev_err[0] = 1'b1; apply();
        check("R4 event while idle ignored", rd_data, 32'h0003_0003);
        send_req[0] = 1'b1; apply();
        bus_wr(4'b0001, 32'h80);
        check("R8 abort mb0 pending", rd_data, 32'h0003_0080);
        send_req[0] = 1'b1; apply();
        check("R3 send while pending ignored", rd_data, 32'h0003_0080);
        ev_abort_done[0] = 1'b1; apply();
        check("R9 abort done mb0", rd_data, 32'h0003_0001);
        check("R9 abort_pend cleared", {29'h0, abort_pend}, 32'h0);
    endtask

    task automatic t_layout();
        send_req[2] = 1'b1; apply();
        ev_arb_lost[2] = 1'b1; ev_err[2] = 1'b1; apply();
        check("R1 lane 2 layout", rd_data, 32'h000D_0001);
        bus_wr(4'b1111, 32'hFFFF_FFFF);
        check("R1 reserved and upper byte zero", rd_data, 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst = 1'b0;
        #1;
        t_reset();
        t_send_ok();
        t_arb_err();
        t_clear();
        t_set_wins();
        t_abort_idle();
        t_layout();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule